// File: doc/BRIEF.md
# Dual-Clock Presettable Up/Down Counter

The block is a binary up/down counter with one clock input for counting up and another for counting down. Each count clock is an ordinary data input. It is brought into the system clock domain by a synchronizer chain, and a rising-edge detector turns it into a count event. An edge on one count clock produces a count only while the other count clock is high. A level-sensitive clear and a level-sensitive parallel load override counting, and clear wins when both are active.

Two active-low terminal flags are derived from the count and the synchronized clock levels. Carry goes low at the top value while the up clock is low. Borrow goes low at zero while the down clock is low. The flag returns high when the clock rises again. That rising edge counts the next stage, so stages chain directly: carry drives the next stage's up clock and borrow drives its down clock. The counter width and the synchronizer depth are parameters.

Top module: `updn_dual_clk_ctr`

## Requirements
- R1: While `rst_n` is low, `count` is 0. With both count clocks high, `carry_n` and `borrow_n` are 1 after reset.
- R2: A rising edge of `up_clk` while `dn_clk` is high adds one to `count`, and the top value (all ones) wraps to 0.
- R3: A rising edge of `dn_clk` while `up_clk` is high subtracts one from `count`, and 0 wraps to all ones.
- R4: A rising edge of one count clock while the other count clock is low leaves `count` unchanged.
- R5: When both count clocks rise in the same synchronized cycle, each edge is qualified and the two steps cancel, so `count` does not change.
- R6: While `clr` is high, `count` becomes 0 at the next `clk` edge. Both count clocks and `load_n` are ignored.
- R7: While `load_n` is low and `clr` is low, `count` takes the value of `jam` at the next `clk` edge. Count edges that occur during this time are discarded.
- R8: `carry_n` is low exactly when `count` is all ones and the synchronized `up_clk` is low.
- R9: `borrow_n` is low exactly when `count` is 0 and the synchronized `dn_clk` is low.
- R10: Two stages chained through `carry_n`→`up_clk` and `borrow_n`→`dn_clk` form a counter of twice the width that counts up and down through both wrap points.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all state updates on its rising edge |
| rst_n | input | 1 | Asynchronous active-low system reset |
| up_clk | input | 1 | Count-up clock, sampled asynchronously |
| dn_clk | input | 1 | Count-down clock, sampled asynchronously |
| clr | input | 1 | Active-high master clear, level sensitive |
| load_n | input | 1 | Active-low parallel load enable, level sensitive |
| jam | input | WIDTH | Parallel load value |
| count | output | WIDTH | Current count |
| carry_n | output | 1 | Active-low terminal-count flag for up counting |
| borrow_n | output | 1 | Active-low terminal-count flag for down counting |

## Verification
The up step and the down step can be due in the same synchronized cycle. The bench provokes this by dropping both count clocks together and raising them together. It then judges that the chained count has not moved. A second collision occurs when a count edge arrives while clear or load is held. The bench toggles `up_clk` during load and during clear and expects exactly the loaded value or zero once the override is released.

// File: rtl/updn_pkg.sv
package updn_pkg;
   typedef enum logic [1:0] {
      STEP_HOLD = 2'd0,
      STEP_INC  = 2'd1,
      STEP_DEC  = 2'd2
   } step_e;
endpackage

// File: rtl/updn_edge_sync.sv
module updn_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic level_o,
   output logic rise_o
);
   logic [STAGES-1:0] chain_q;
   logic              prev_q;

   // idle level of a count clock is high, so reset the chain to ones
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= '1;
         prev_q  <= 1'b1;
      end else begin
         chain_q <= {chain_q[STAGES-2:0], async_in};
         prev_q  <= chain_q[STAGES-1];
      end
   end

   assign level_o = chain_q[STAGES-1];
   assign rise_o  = chain_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/updn_step_arb.sv
module updn_step_arb
   import updn_pkg::*;
(
   input  logic  up_rise,
   input  logic  up_lvl,
   input  logic  dn_rise,
   input  logic  dn_lvl,
   output step_e step
);
   logic inc_ok;
   logic dec_ok;

   assign inc_ok = up_rise & dn_lvl;
   assign dec_ok = dn_rise & up_lvl;

   always_comb begin
      case ({inc_ok, dec_ok})
         2'b10:   step = STEP_INC;
         2'b01:   step = STEP_DEC;
         default: step = STEP_HOLD;   // none, or both cancelling
      endcase
   end
endmodule

// File: rtl/updn_count_reg.sv
module updn_count_reg
   import updn_pkg::*;
#(
   parameter int WIDTH = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             load_n,
   input  logic [WIDTH-1:0] jam,
   input  step_e            step,
   output logic [WIDTH-1:0] count
);
   logic [WIDTH-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clr) begin
         cnt_q <= '0;
      end else if (!load_n) begin
         cnt_q <= jam;
      end else begin
         case (step)
            STEP_INC: cnt_q <= cnt_q + WIDTH'(1);
            STEP_DEC: cnt_q <= cnt_q - WIDTH'(1);
            default:  cnt_q <= cnt_q;
         endcase
      end
   end

   assign count = cnt_q;
endmodule

// File: rtl/updn_term_detect.sv
module updn_term_detect #(
   parameter int WIDTH = 4
) (
   input  logic [WIDTH-1:0] count,
   input  logic             up_lvl,
   input  logic             dn_lvl,
   output logic             carry_n,
   output logic             borrow_n
);
   localparam logic [WIDTH-1:0] TOP_VAL = '1;
   localparam logic [WIDTH-1:0] BOT_VAL = '0;

   logic at_top;
   logic at_bot;

   assign at_top   = (count == TOP_VAL);
   assign at_bot   = (count == BOT_VAL);
   assign carry_n  = ~(at_top & ~up_lvl);
   assign borrow_n = ~(at_bot & ~dn_lvl);
endmodule

// File: rtl/updn_dual_clk_ctr.sv
module updn_dual_clk_ctr
   import updn_pkg::*;
#(
   parameter int WIDTH       = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             up_clk,
   input  logic             dn_clk,
   input  logic             clr,
   input  logic             load_n,
   input  logic [WIDTH-1:0] jam,
   output logic [WIDTH-1:0] count,
   output logic             carry_n,
   output logic             borrow_n
);
   localparam int N_CLK  = 2;
   localparam int IDX_UP = 0;
   localparam int IDX_DN = 1;

   generate
      if (WIDTH < 1) begin : g_bad_width
         $error("updn_dual_clk_ctr: WIDTH must be at least 1");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("updn_dual_clk_ctr: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [N_CLK-1:0] raw_clk;
   logic [N_CLK-1:0] lvl;
   logic [N_CLK-1:0] rise;
   step_e            step;

   assign raw_clk[IDX_UP] = up_clk;
   assign raw_clk[IDX_DN] = dn_clk;

   for (genvar g = 0; g < N_CLK; g++) begin : g_sync
      updn_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
         .clk      (clk),
         .rst_n    (rst_n),
         .async_in (raw_clk[g]),
         .level_o  (lvl[g]),
         .rise_o   (rise[g])
      );
   end

   updn_step_arb u_arb (
      .up_rise (rise[IDX_UP]),
      .up_lvl  (lvl[IDX_UP]),
      .dn_rise (rise[IDX_DN]),
      .dn_lvl  (lvl[IDX_DN]),
      .step    (step)
   );

   updn_count_reg #(.WIDTH(WIDTH)) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (clr),
      .load_n (load_n),
      .jam    (jam),
      .step   (step),
      .count  (count)
   );

   updn_term_detect #(.WIDTH(WIDTH)) u_term (
      .count    (count),
      .up_lvl   (lvl[IDX_UP]),
      .dn_lvl   (lvl[IDX_DN]),
      .carry_n  (carry_n),
      .borrow_n (borrow_n)
   );
endmodule

// File: rtl/updn_dual_clk_ctr_chk.sv
module updn_dual_clk_ctr_chk #(
   parameter int WIDTH = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             clr,
   input logic             load_n,
   input logic [WIDTH-1:0] jam,
   input logic [WIDTH-1:0] count,
   input logic             carry_n,
   input logic             borrow_n
);
   // R6
   clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (count == '0));

   // R7
   load_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && !load_n) |=> (count == $past(jam)));

   // R2 R3
   single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && load_n) |=> ((count == $past(count)) ||
                            (count == $past(count) + WIDTH'(1)) ||
                            (count == $past(count) - WIDTH'(1))));

   // R8
   carry_at_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !carry_n |-> (count == {WIDTH{1'b1}}));

   // R9
   borrow_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !borrow_n |-> (count == '0));

   // R8 R9
   flags_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (WIDTH > 1) |-> (carry_n || borrow_n));
endmodule

bind updn_dual_clk_ctr updn_dual_clk_ctr_chk #(.WIDTH(WIDTH)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .clr      (clr),
   .load_n   (load_n),
   .jam      (jam),
   .count    (count),
   .carry_n  (carry_n),
   .borrow_n (borrow_n)
);

// File: tb/test_updn_dual_clk_ctr.sv
module test_updn_dual_clk_ctr;
   localparam int CLK_PERIOD = 10;
   localparam int W          = 4;

   logic         clk = 1'b0;
   logic         rst_n;
   logic         up_clk, dn_clk, clr, load_n;
   logic [W-1:0] jam_lo, jam_hi;
   logic [W-1:0] cnt_lo, cnt_hi;
   logic         carry_lo, borrow_lo, carry_hi, borrow_hi;
   logic [7:0]   exp_val;
   int           n_checks = 0;
   int           n_errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   updn_dual_clk_ctr #(.WIDTH(W)) i_updn_dual_clk_ctr (
      .clk(clk), .rst_n(rst_n), .up_clk(up_clk), .dn_clk(dn_clk),
      .clr(clr), .load_n(load_n), .jam(jam_lo),
      .count(cnt_lo), .carry_n(carry_lo), .borrow_n(borrow_lo)
   );

   // R10 chained upper stage
   updn_dual_clk_ctr #(.WIDTH(W)) i_updn_dual_clk_ctr_hi (
      .clk(clk), .rst_n(rst_n), .up_clk(carry_lo), .dn_clk(borrow_lo),
      .clr(clr), .load_n(load_n), .jam(jam_hi),
      .count(cnt_hi), .carry_n(carry_hi), .borrow_n(borrow_hi)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic settle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check_total(input string req);
      check(req, {24'd0, cnt_hi, cnt_lo}, {24'd0, exp_val});
   endtask

   task automatic tick_up();
      up_clk = 1'b0;
      settle(8);
      check("R8 carry", {31'd0, carry_lo}, {31'd0, exp_val[3:0] != 4'hF});
      up_clk = 1'b1;
      settle(10);
      exp_val = exp_val + 8'd1;
      check("R2 R10 up", {24'd0, cnt_hi, cnt_lo}, {24'd0, exp_val});
   endtask

   task automatic tick_dn();
      dn_clk = 1'b0;
      settle(8);
      check("R9 borrow", {31'd0, borrow_lo}, {31'd0, exp_val[3:0] != 4'h0});
      dn_clk = 1'b1;
      settle(10);
      exp_val = exp_val - 8'd1;
      check("R3 R10 down", {24'd0, cnt_hi, cnt_lo}, {24'd0, exp_val});
   endtask

   task automatic t_reset();
      rst_n = 1'b0; up_clk = 1'b1; dn_clk = 1'b1; clr = 1'b0; load_n = 1'b1;
      jam_lo = '0; jam_hi = '0;
      settle(3);
      check("R1 count in reset", {28'd0, cnt_lo}, 32'd0);
      rst_n = 1'b1;
      settle(3);
      exp_val = 8'd0;
      check_total("R1 count");
      check("R1 carry", {31'd0, carry_lo}, 32'd1);
      check("R1 borrow", {31'd0, borrow_lo}, 32'd1);
   endtask

   task automatic t_down_wrap();
      for (int i = 0; i < 20; i++) tick_dn();
   endtask

   task automatic t_up_wrap();
      for (int i = 0; i < 40; i++) tick_up();
   endtask

   task automatic t_preset();
      jam_lo = 4'h5; jam_hi = 4'h3;
      load_n = 1'b0;
      settle(2);
      up_clk = 1'b0;
      settle(6);
      up_clk = 1'b1;
      settle(6);
      load_n = 1'b1;
      settle(8);
      exp_val = 8'h35;
      check_total("R7 preset ignores up edge");
   endtask

   task automatic t_gated();
      dn_clk = 1'b0;
      settle(8);
      up_clk = 1'b0;
      settle(8);
      up_clk = 1'b1;
      settle(10);
      check_total("R4 up edge with down low");
      dn_clk = 1'b1;
      settle(10);
      exp_val = exp_val - 8'd1;
      check_total("R3 down edge with up high");
   endtask

   task automatic t_both();
      up_clk = 1'b0; dn_clk = 1'b0;
      settle(8);
      up_clk = 1'b1; dn_clk = 1'b1;
      settle(10);
      check_total("R5 simultaneous edges cancel");
   endtask

   task automatic t_clear();
      jam_lo = 4'h9; jam_hi = 4'h9;
      load_n = 1'b0;
      clr    = 1'b1;
      settle(2);
      up_clk = 1'b0;
      settle(6);
      up_clk = 1'b1;
      settle(6);
      exp_val = 8'h00;
      check_total("R6 clear beats load");
      clr = 1'b0;
      settle(4);
      exp_val = 8'h99;
      check_total("R7 load after clear");
      load_n = 1'b1;
      settle(4);
      tick_up();
      tick_dn();
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      n_errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

   initial begin
      t_reset();
      t_down_wrap();
      t_up_wrap();
      t_preset();
      t_gated();
      t_both();
      t_clear();
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end
endmodule